// File: doc/BRIEF.md
# Circuit-Switched Linear Stream Switch

This block is one node in a one-dimensional chain of stream switches. Each node links rightward to its right neighbour, leftward to its left neighbour, and to the computing modules attached at its own position. A producer opens a dedicated route by presenting an address header and raising its request line. The header holds a target node coordinate and a local port number. Each node on the way claims a free link toward the target and passes the header and the request on. When the header reaches the target node, that node hands it to the addressed local output.

The acknowledge from the consumer, the consumer's full flag and, later, the stream words all travel along the claimed links. Stream words move forward with exactly one register per hop. The acknowledge and full flag travel backward with no register. The route exists only while the request stays high. Dropping the request releases every hop in turn.

Inputs and outputs are flattened into index spaces. Inputs: 0..NR-1 arrive from the left neighbour, NR..NR+NL-1 arrive from the right neighbour, and the local producer ports come last. Outputs: 0..NR-1 go to the right neighbour, NR..NR+NL-1 go to the left neighbour, and the local consumer ports come last.

Top module: `stream_switch`

## Requirements
- R1: A header on an unrouted input, with its valid bit set and the request high, asks for a link on a side chosen by comparing coordinates. A target X above MY_X asks for a rightward output; a target X below MY_X asks for a leftward output. The lowest-numbered free output of that side is taken.
- R2: A header whose target X equals MY_X is routed to local output number NR+NL+lid.
- R3: Reachability is fixed. Inputs from the left may reach rightward and local outputs. Inputs from the right may reach leftward and local outputs. Local inputs may reach leftward and rightward outputs. A request for an unreachable output is never granted.
- R4: The header and the request appear on the chosen output two clock edges after the producer drives them. The first edge loads the input register and the second edge records the claim.
- R5: While a route is held, the acknowledge on its output appears on its input in the same cycle. No input acknowledges without a route.
- R6: Once a route is held, each word on the input, with bit W-1 (valid), bit W-2 (end of stream) and the payload bits W-3:0, appears unchanged on the output one edge later.
- R7: The full flag on a routed output appears on its input in the same cycle.
- R8: A route stays while the request stays high. One edge after the input request falls, the output request falls. One edge after that, the link is free again.
- R9: When no free reachable output exists, the request waits with no acknowledge and no forwarded request. It is served once a link frees.
- R10: When several inputs compete for the same output in one cycle, the lowest input index wins.
- R11: After reset, no output request is raised, no output data is driven and no input is acknowledged.
- R12: An input holds at most one output, and an output serves at most one input.
- Header layout: lid occupies bits LW-1:0 and X occupies bits LW+XW-1:LW. XW is ceil(log2 N) and LW is ceil(log2 KO), each at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | NIN*W | Stream words of all inputs, input i at bits i*W +: W |
| in_req | input | NIN | Route request per input |
| in_ack | output | NIN | Route acknowledge returned per input |
| in_full | output | NIN | Downstream full flag returned per input |
| out_data | output | NOUT*W | Stream words of all outputs |
| out_req | output | NOUT | Forwarded route request per output |
| out_ack | input | NOUT | Acknowledge from the downstream node or consumer |
| out_full | input | NOUT | Full flag from the downstream node or consumer |

## Verification
Forwarded headers and requests are due two edges after they are driven. Data words are due one edge later, and a dropped request shows on the output one edge later. The acknowledge and full flag are combinational and are read one time step after the output-side value changes. The bench drives on falling edges and counts whole falling edges before each sample. Contention cases wait one extra edge for each lost arbitration round and one extra edge for each release.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [1:0] {SIDE_LEFT, SIDE_RIGHT, SIDE_LOCAL} side_e;

  // side an input arrives from: left neighbour, right neighbour, local producer
  function automatic side_e in_side(int i, int nr, int nl);
    if (i < nr) return SIDE_LEFT;
    if (i < nr + nl) return SIDE_RIGHT;
    return SIDE_LOCAL;
  endfunction

  // side an output leaves toward: right neighbour, left neighbour, local consumer
  function automatic side_e out_side(int o, int nr, int nl);
    if (o < nr) return SIDE_RIGHT;
    if (o < nr + nl) return SIDE_LEFT;
    return SIDE_LOCAL;
  endfunction

  // traffic never turns back toward the side it came from
  function automatic bit can_reach(int i, int o, int nr, int nl);
    return in_side(i, nr, nl) != out_side(o, nr, nl);
  endfunction

  // does a header (tx, lid) ask for output o at node my_x
  function automatic bit header_wants(int o, int nr, int nl, int tx, int lid, int my_x);
    case (out_side(o, nr, nl))
      SIDE_RIGHT: return tx > my_x;
      SIDE_LEFT:  return tx < my_x;
      default:    return (tx == my_x) && (lid == o - nr - nl);
    endcase
  endfunction

endpackage

// File: rtl/sw_in_stage.sv
module sw_in_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic         req,
  output logic [W-1:0] q,
  output logic         req_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q     <= '0;
      req_q <= 1'b0;
    end else begin
      q     <= d;
      req_q <= req;
    end
  end

endmodule

// File: rtl/sw_alloc.sv
module sw_alloc
  import sw_pkg::*;
#(
  parameter int NIN  = 6,
  parameter int NOUT = 6,
  parameter int NR   = 2,
  parameter int NL   = 2,
  parameter int XW   = 2,
  parameter int LW   = 1,
  parameter int SW   = 3,
  parameter int MY_X = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIN-1:0]       req_q,
  input  logic [NIN*(XW+LW+1)-1:0] hdr_q,
  output logic [NOUT-1:0]      own_vld,
  output logic [NOUT*SW-1:0]   own_src,
  output logic [NOUT-1:0]      grant,
  output logic [NIN-1:0]       bound
);

  localparam int HW = XW + LW + 1;

  logic [NOUT-1:0] cand [NIN];
  logic [NOUT-1:0] pick [NIN];
  logic [SW-1:0]   gnt_src [NOUT];
  logic [SW-1:0]   src_r   [NOUT];

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      logic [HW-1:0] h;
      logic          found;
      h = hdr_q[i*HW +: HW];
      found = 1'b0;
      pick[i] = '0;
      for (int o = 0; o < NOUT; o++) begin
        cand[i][o] = req_q[i] && h[HW-1] && !bound[i] && !own_vld[o]
                     && can_reach(i, o, NR, NL)
                     && header_wants(o, NR, NL, int'(h[LW +: XW]), int'(h[LW-1:0]), MY_X);
        if (!found && cand[i][o]) begin
          pick[i][o] = 1'b1;
          found = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int o = 0; o < NOUT; o++) begin
      grant[o] = 1'b0;
      gnt_src[o] = '0;
      for (int i = 0; i < NIN; i++) begin
        if (!grant[o] && pick[i][o]) begin
          grant[o] = 1'b1;
          gnt_src[o] = SW'(i);
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      bound[i] = 1'b0;
      for (int o = 0; o < NOUT; o++)
        if (own_vld[o] && src_r[o] == SW'(i)) bound[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int o = 0; o < NOUT; o++) begin
        own_vld[o] <= 1'b0;
        src_r[o]   <= '0;
      end
    end else begin
      for (int o = 0; o < NOUT; o++) begin
        if (own_vld[o] && !req_q[src_r[o]]) begin
          own_vld[o] <= 1'b0;
        end else if (grant[o]) begin
          own_vld[o] <= 1'b1;
          src_r[o]   <= gnt_src[o];
        end
      end
    end
  end

  always_comb
    for (int o = 0; o < NOUT; o++) own_src[o*SW +: SW] = src_r[o];

endmodule

// File: rtl/sw_xbar.sv
module sw_xbar #(
  parameter int NIN  = 6,
  parameter int NOUT = 6,
  parameter int W    = 8,
  parameter int SW   = 3
) (
  input  logic [NIN*W-1:0]    dat_q,
  input  logic [NIN-1:0]      req_q,
  input  logic [NOUT-1:0]     own_vld,
  input  logic [NOUT*SW-1:0]  own_src,
  input  logic [NOUT-1:0]     out_ack,
  input  logic [NOUT-1:0]     out_full,
  output logic [NOUT*W-1:0]   out_data,
  output logic [NOUT-1:0]     out_req,
  output logic [NIN-1:0]      in_ack,
  output logic [NIN-1:0]      in_full
);

  always_comb begin
    for (int o = 0; o < NOUT; o++) begin
      logic [SW-1:0] s;
      s = own_src[o*SW +: SW];
      out_req[o] = own_vld[o] && req_q[s];
      out_data[o*W +: W] = own_vld[o] ? dat_q[int'(s)*W +: W] : '0;
    end
  end

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      in_ack[i]  = 1'b0;
      in_full[i] = 1'b0;
      for (int o = 0; o < NOUT; o++) begin
        if (own_vld[o] && own_src[o*SW +: SW] == SW'(i)) begin
          in_ack[i]  = in_ack[i] | out_ack[o];
          in_full[i] = in_full[i] | out_full[o];
        end
      end
    end
  end

endmodule

// File: rtl/stream_switch.sv
module stream_switch #(
  parameter int N    = 4,
  parameter int MY_X = 1,
  parameter int W    = 8,
  parameter int NR   = 2,
  parameter int NL   = 2,
  parameter int KI   = 2,
  parameter int KO   = 2,
  localparam int NIN  = NR + NL + KI,
  localparam int NOUT = NR + NL + KO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIN*W-1:0]  in_data,
  input  logic [NIN-1:0]    in_req,
  output logic [NIN-1:0]    in_ack,
  output logic [NIN-1:0]    in_full,
  output logic [NOUT*W-1:0] out_data,
  output logic [NOUT-1:0]   out_req,
  input  logic [NOUT-1:0]   out_ack,
  input  logic [NOUT-1:0]   out_full
);

  localparam int XW = (N  > 1) ? $clog2(N)   : 1;
  localparam int LW = (KO > 1) ? $clog2(KO)  : 1;
  localparam int SW = (NIN > 1) ? $clog2(NIN) : 1;
  localparam int HW = XW + LW + 1;

  logic [NIN*W-1:0]   dat_q;
  logic [NIN-1:0]     req_q;
  logic [NIN*HW-1:0]  hdr_q;
  logic [NOUT-1:0]    own_vld;
  logic [NOUT*SW-1:0] own_src;
  logic [NOUT-1:0]    grant;
  logic [NIN-1:0]     bound;
  logic [NOUT-1:0]    out_hdr_vld;

  for (genvar i = 0; i < NIN; i++) begin : g_in
    sw_in_stage #(.W(W)) i_stage (
      .clk(clk), .rst_n(rst_n),
      .d(in_data[i*W +: W]), .req(in_req[i]),
      .q(dat_q[i*W +: W]), .req_q(req_q[i])
    );
    assign hdr_q[i*HW +: HW] = {dat_q[i*W + W - 1], dat_q[i*W +: XW + LW]};
  end

  sw_alloc #(
    .NIN(NIN), .NOUT(NOUT), .NR(NR), .NL(NL),
    .XW(XW), .LW(LW), .SW(SW), .MY_X(MY_X)
  ) i_alloc (
    .clk(clk), .rst_n(rst_n), .req_q(req_q), .hdr_q(hdr_q),
    .own_vld(own_vld), .own_src(own_src), .grant(grant), .bound(bound)
  );

  sw_xbar #(.NIN(NIN), .NOUT(NOUT), .W(W), .SW(SW)) i_xbar (
    .dat_q(dat_q), .req_q(req_q), .own_vld(own_vld), .own_src(own_src),
    .out_ack(out_ack), .out_full(out_full),
    .out_data(out_data), .out_req(out_req), .in_ack(in_ack), .in_full(in_full)
  );

  for (genvar o = 0; o < NOUT; o++) begin : g_hv
    assign out_hdr_vld[o] = out_data[o*W + W - 1];
  end

endmodule

// File: rtl/sw_route_chk.sv
module sw_route_chk
  import sw_pkg::*;
#(
  parameter int NIN  = 6,
  parameter int NOUT = 6,
  parameter int NR   = 2,
  parameter int NL   = 2,
  parameter int SW   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NOUT-1:0]    own_vld,
  input logic [NOUT*SW-1:0] own_src,
  input logic [NOUT-1:0]    out_req,
  input logic [NOUT-1:0]    out_hdr_vld,
  input logic [NIN-1:0]     in_ack
);

  logic [NOUT-1:0] held_by [NIN];
  logic [NOUT-1:0] legal;

  always_comb begin
    for (int i = 0; i < NIN; i++)
      for (int o = 0; o < NOUT; o++)
        held_by[i][o] = own_vld[o] && own_src[o*SW +: SW] == SW'(i);
    for (int o = 0; o < NOUT; o++)
      legal[o] = can_reach(int'(own_src[o*SW +: SW]), o, NR, NL);
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_o
    AST_HDR_ON_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(own_vld[o]) |-> out_hdr_vld[o]); // R4
    AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      own_vld[o] && out_req[o] |=> own_vld[o]); // R8
    AST_ROUTE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      own_vld[o] && !out_req[o] |=> !own_vld[o]); // R8
    AST_SIDE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      own_vld[o] |-> legal[o]); // R3
  end

  for (genvar i = 0; i < NIN; i++) begin : g_i
    AST_ONE_LINK_PER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(held_by[i]) <= 1); // R12
    AST_ACK_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      in_ack[i] |-> (|held_by[i])); // R5
  end

endmodule

bind stream_switch sw_route_chk #(
  .NIN(NIN), .NOUT(NOUT), .NR(NR), .NL(NL), .SW(SW)
) i_route_chk (
  .clk(clk), .rst_n(rst_n), .own_vld(own_vld), .own_src(own_src),
  .out_req(out_req), .out_hdr_vld(out_hdr_vld), .in_ack(in_ack)
);

// File: tb/test_stream_switch.sv
`timescale 1ns/1ps
module test_stream_switch;

  localparam int N = 4, MY_X = 1, W = 8, NR = 2, NL = 2, KI = 2, KO = 2;
  localparam int NIN = NR + NL + KI, NOUT = NR + NL + KO;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NIN*W-1:0]  in_data = '0;
  logic [NIN-1:0]    in_req = '0;
  logic [NIN-1:0]    in_ack, in_full;
  logic [NOUT*W-1:0] out_data;
  logic [NOUT-1:0]   out_req;
  logic [NOUT-1:0]   out_ack = '0, out_full = '0;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stream_switch #(.N(N), .MY_X(MY_X), .W(W), .NR(NR), .NL(NL), .KI(KI), .KO(KO))
    i_stream_switch (.*);

  function automatic logic [W-1:0] hdr(int x, int lid);
    return {1'b1, 1'b0, 6'((x << 1) | lid)};
  endfunction

  // expected output for a lone request, -1 when it must wait forever
  function automatic int exp_out(int i, int x, int lid);
    bit from_left  = (i < NR);
    bit from_right = (i >= NR) && (i < NR + NL);
    if (x > MY_X) return from_right ? -1 : 0;
    if (x < MY_X) return from_left ? -1 : NR;
    return (from_left || from_right) ? NR + NL + lid : -1;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(int i, logic [W-1:0] d, logic r);
    in_data[i*W +: W] = d;
    in_req[i] = r;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    if (!done) $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    out_ack = '1;
    #1;
    check("R11 out_req", int'(out_req), 0);
    check("R11 out_data", int'(out_data), 0);
    check("R11 in_ack", int'(in_ack), 0);
    out_ack = '0;
    rst_n = 1'b1;
    tick(1);

    // sweep every input against every target
    for (int i = 0; i < NIN; i++)
      for (int x = 0; x < N; x++)
        for (int lid = 0; lid < KO; lid++) begin
          int e;
          e = exp_out(i, x, lid);
          drive(i, hdr(x, lid), 1'b1);
          tick(2);
          check($sformatf("R1 R2 R3 route i%0d x%0d l%0d", i, x, lid),
                int'(out_req), (e < 0) ? 0 : (1 << e));
          if (e >= 0) begin
            logic [W-1:0] w1, w2;
            check("R4 header", int'(out_data[e*W +: W]), int'(hdr(x, lid)));
            out_ack[e] = 1'b1;
            #1 check("R5 ack back", int'(in_ack), 1 << i);
            w1 = {1'b1, 1'b0, 6'(i * 8 + x * 2 + lid)};
            w2 = {1'b1, 1'b1, 6'(63 - i)};
            drive(i, w1, 1'b1);
            tick(1);
            check("R6 data", int'(out_data[e*W +: W]), int'(w1));
            drive(i, w2, 1'b1);
            tick(1);
            check("R6 eos", int'(out_data[e*W +: W]), int'(w2));
            out_full[e] = 1'b1;
            #1 check("R7 full back", int'(in_full), 1 << i);
            out_full[e] = 1'b0;
            drive(i, '0, 1'b0);
            tick(1);
            check("R8 req drop", int'(out_req), 0);
            tick(1);
            out_ack = '0;
          end else begin
            check("R3 no ack", int'(in_ack), 0);
            drive(i, '0, 1'b0);
            tick(2);
          end
        end

    // two rightward requests at once, then a third that must wait
    drive(0, hdr(3, 0), 1'b1);
    drive(1, hdr(3, 0), 1'b1);
    tick(3);
    check("R10 R12 two links", int'(out_req), 6'b000011);
    out_ack = '1;
    #1 check("R5 two acks", int'(in_ack), 6'b000011);
    drive(4, hdr(2, 0), 1'b1);
    tick(3);
    check("R9 waits req", int'(out_req), 6'b000011);
    check("R9 waits ack", int'(in_ack), 6'b000011);
    drive(0, '0, 1'b0);
    tick(3);
    check("R9 served req", int'(out_req), 6'b000011);
    check("R9 served hdr", int'(out_data[0 +: W]), int'(hdr(2, 0)));
    check("R9 served ack", int'(in_ack), 6'b010010);
    drive(1, '0, 1'b0);
    drive(4, '0, 1'b0);
    tick(2);
    check("R8 all free", int'(out_req), 0);
    out_ack = '0;

    // same local output from both neighbours: lower index wins
    drive(0, hdr(1, 0), 1'b1);
    drive(2, hdr(1, 0), 1'b1);
    tick(2);
    check("R10 local winner req", int'(out_req), 6'b010000);
    out_ack = '1;
    #1 check("R10 local winner ack", int'(in_ack), 6'b000001);
    drive(0, '0, 1'b0);
    tick(3);
    check("R9 loser served", int'(in_ack), 6'b000100);
    drive(2, '0, 1'b0);
    tick(2);
    out_ack = '0;
    check("R8 idle end", int'(out_req), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule